// File: doc/BRIEF.md
# I2C Write-Only Bus Master

This block drives a two-wire serial bus as a master that only sends. A host programs the 7-bit target address, a direction bit and the SCL low and high timing. It then turns the master on and writes bytes into a one-byte holding register. The first byte written while the bus is idle starts a transfer. The block issues the start condition and sends the address byte. It then sends each held byte, most significant bit first, and checks the receiver's acknowledge after every byte.

Each acknowledge frees the holding register and raises the ready flag, so the host can load the next byte while the current one is on the wire. If the holding register is still empty when a byte completes, the block ends the transfer with a stop condition. A missing acknowledge also ends the transfer, and any pending byte is dropped. When the bus has been released after the stop, the completion flag rises.

The three status flags can each be routed to a single interrupt line. The clock and data wires are open-drain, so each is modelled as a pull-down enable. SDA also has a sense input.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, scl_oe=0, sda_oe=0, txrdy=1, txcomp=1, nack=0, irq=0, the interrupt mask is all zero and the master is off. Both wires stay released whenever no transfer is in progress.
- R2: A data write (wr_addr=3, byte in wr_data[7:0]) while the master is on and the bus is idle starts a transfer. The block pulls SDA low with SCL released, then sends the address byte {wr_data[6:0], wr_data[7]} most significant bit first. That byte holds the 7-bit target address and the direction bit, as last written at wr_addr=0.
- R3: Data bytes go out MSB first, in the order they were written. At each acknowledge the held byte moves into the shifter and txrdy is set. A data write clears txrdy on the next cycle.
- R4: On the ninth SCL pulse of each byte, the block releases SDA and samples it at the end of the high phase. A low level counts as an acknowledge.
- R5: A high level on the ninth pulse sets nack, drops the held byte, sets txrdy and issues a stop. Data writes made during the stop sequence are ignored, so no further transfer follows.
- R6: If no byte is held when a byte is acknowledged, the block issues a stop: SDA rises while SCL is released. After a further bus-free time equal to one high phase, txcomp is set.
- R7: The clock register (wr_addr=1) holds three fields: the low divider L in bits [7:0], the high divider H in bits [15:8] and the exponent E in bits [18:16]. SCL is held low for (L<<E)+4 clocks and released for (H<<E)+4 clocks.
- R8: While SCL is released, SDA changes only to form a start condition or a stop condition.
- R9: The control register (wr_addr=2) turns the master on with bit 0 and off with bit 1; bit 1 wins if both are set. Data writes made while the master is off are discarded.
- R10: irq is the OR of the flags enabled in the mask. Flag bit 0 is txcomp, bit 1 is txrdy and bit 2 is nack. Writing wr_addr=4 sets the mask bits given by ones in wr_data[2:0]; writing wr_addr=5 clears them.
- R11: Starting a transfer clears both txcomp and nack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 2*DIV_W+EXP_W | Register write value |
| sda_in | input | 1 | Sensed level of the data wire |
| scl_oe | output | 1 | Pull the clock wire low |
| sda_oe | output | 1 | Pull the data wire low |
| txrdy | output | 1 | Holding register free |
| nack | output | 1 | Last transfer ended on a missing acknowledge |
| txcomp | output | 1 | Transfer finished and bus released |
| irq | output | 1 | OR of the enabled flags |

## Verification
The bench builds the block with the default DIV_W=8 and EXP_W=3 and programs small dividers with exponents from 0 to 3. This keeps each SCL phase between 4 and 20 clocks, so full multi-byte transfers stay short. With zero dividers the bench reaches the four-clock floor, and with nonzero exponents it reaches the shifted timing path. A modelled receiver withholds the acknowledge on the address byte in one transfer and on a data byte in another. This reaches both stop paths, the dropped held byte and recovery in the next transfer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    BS_IDLE  = 3'd0,
    BS_START = 3'd1,
    BS_LOW   = 3'd2,
    BS_HIGH  = 3'd3,
    BS_PLOW  = 3'd4,
    BS_PHIGH = 3'd5,
    BS_FREE  = 3'd6
  } bus_st_e;

  typedef struct packed {
    logic start;
    logic ack;
    logic nack;
    logic done;
  } evt_t;

  localparam logic [2:0] REG_MODE    = 3'd0;
  localparam logic [2:0] REG_CLK     = 3'd1;
  localparam logic [2:0] REG_CTRL    = 3'd2;
  localparam logic [2:0] REG_DATA    = 3'd3;
  localparam logic [2:0] REG_IRQ_ON  = 3'd4;
  localparam logic [2:0] REG_IRQ_OFF = 3'd5;

  localparam int NFLAGS      = 3;
  localparam int FLAG_TXCOMP = 0;
  localparam int FLAG_TXRDY  = 1;
  localparam int FLAG_NACK   = 2;

  localparam int ACK_SLOT = 8;

endpackage

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs import i2cm_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 3,
  parameter int WD_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [WD_W-1:0]   wr_data,
  input  logic              stop_busy,
  input  evt_t              evt,
  input  logic              take,
  output logic [6:0]        tgt_addr,
  output logic              dir,
  output logic [DIV_W-1:0]  ldiv,
  output logic [DIV_W-1:0]  hdiv,
  output logic [EXP_W-1:0]  cexp,
  output logic              en,
  output logic [7:0]        hold_data,
  output logic              hold_vld,
  output logic              hold_wr,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);

  logic [6:0]        addr_q, addr_d;
  logic              dir_q, dir_d;
  logic [DIV_W-1:0]  ldiv_q, ldiv_d, hdiv_q, hdiv_d;
  logic [EXP_W-1:0]  exp_q, exp_d;
  logic              en_q, en_d;
  logic [7:0]        hold_q, hold_d;
  logic              hv_q, hv_d;
  logic [NFLAGS-1:0] flg_q, flg_d, msk_q, msk_d;
  logic              sel_data;

  assign sel_data = wr_en && (wr_addr == REG_DATA);
  assign hold_wr  = sel_data && en_q && !stop_busy && !evt.nack;

  // configuration registers
  always_comb begin
    addr_d = addr_q;
    dir_d  = dir_q;
    ldiv_d = ldiv_q;
    hdiv_d = hdiv_q;
    exp_d  = exp_q;
    en_d   = en_q;
    msk_d  = msk_q;
    if (wr_en) begin
      case (wr_addr)
        REG_MODE: begin
          addr_d = wr_data[6:0];
          dir_d  = wr_data[7];
        end
        REG_CLK: begin
          ldiv_d = wr_data[DIV_W-1:0];
          hdiv_d = wr_data[2*DIV_W-1:DIV_W];
          exp_d  = wr_data[2*DIV_W +: EXP_W];
        end
        REG_CTRL: begin
          if (wr_data[0]) en_d = 1'b1;
          if (wr_data[1]) en_d = 1'b0;
        end
        REG_IRQ_ON:  msk_d = msk_q | wr_data[NFLAGS-1:0];
        REG_IRQ_OFF: msk_d = msk_q & ~wr_data[NFLAGS-1:0];
        default: ;
      endcase
    end
  end

  // holding register and status flags
  always_comb begin
    hold_d = hold_q;
    hv_d   = hv_q;
    flg_d  = flg_q;
    if (hold_wr) hold_d = wr_data[7:0];

    if (evt.nack)    hv_d = 1'b0;
    else if (hold_wr) hv_d = 1'b1;
    else if (take)   hv_d = 1'b0;

    if (evt.nack)      flg_d[FLAG_TXRDY] = 1'b1;
    else if (hold_wr)  flg_d[FLAG_TXRDY] = 1'b0;
    else if (evt.ack)  flg_d[FLAG_TXRDY] = 1'b1;

    if (evt.start)     flg_d[FLAG_TXCOMP] = 1'b0;
    else if (evt.done) flg_d[FLAG_TXCOMP] = 1'b1;

    if (evt.start)     flg_d[FLAG_NACK] = 1'b0;
    else if (evt.nack) flg_d[FLAG_NACK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
      ldiv_q <= '0;
      hdiv_q <= '0;
      exp_q  <= '0;
      en_q   <= 1'b0;
      msk_q  <= '0;
      hold_q <= '0;
      hv_q   <= 1'b0;
      flg_q  <= NFLAGS'((1 << FLAG_TXCOMP) | (1 << FLAG_TXRDY));
    end else begin
      addr_q <= addr_d;
      dir_q  <= dir_d;
      ldiv_q <= ldiv_d;
      hdiv_q <= hdiv_d;
      exp_q  <= exp_d;
      en_q   <= en_d;
      msk_q  <= msk_d;
      hold_q <= hold_d;
      hv_q   <= hv_d;
      flg_q  <= flg_d;
    end
  end

  assign tgt_addr  = addr_q;
  assign dir       = dir_q;
  assign ldiv      = ldiv_q;
  assign hdiv      = hdiv_q;
  assign cexp      = exp_q;
  assign en        = en_q;
  assign hold_data = hold_q;
  assign hold_vld  = hv_q;
  assign flags     = flg_q;
  assign irq       = |(flg_q & msk_q);

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold_vld,
  input  logic [7:0]       hold_data,
  input  logic [6:0]       tgt_addr,
  input  logic             dir,
  input  logic [DIV_W-1:0] ldiv,
  input  logic [DIV_W-1:0] hdiv,
  input  logic [EXP_W-1:0] cexp,
  input  logic             sda_in,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             take,
  output evt_t             evt,
  output logic             stop_busy,
  output bus_st_e          st,
  output logic             scl_oe,
  output logic             sda_oe
);

  localparam logic [3:0] ACK_IDX = 4'(ACK_SLOT);

  bus_st_e    st_q, st_d;
  logic [7:0] sh_q, sh_d;
  logic [3:0] bi_q, bi_d;
  logic [CNT_W-1:0] lo_len, hi_len;

  function automatic logic [CNT_W-1:0] phase_len(input logic [DIV_W-1:0] d,
                                                 input logic [EXP_W-1:0] e);
    phase_len = (CNT_W'(d) << e) + CNT_W'(4);
  endfunction

  assign lo_len = phase_len(ldiv, cexp);
  assign hi_len = phase_len(hdiv, cexp);

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    bi_d     = bi_q;
    tmr_load = 1'b0;
    tmr_val  = lo_len;
    take     = 1'b0;
    evt      = '0;
    case (st_q)
      BS_IDLE: begin
        if (en && hold_vld) begin
          st_d      = BS_START;
          tmr_load  = 1'b1;
          tmr_val   = hi_len;
          sh_d      = {tgt_addr, dir};
          bi_d      = '0;
          evt.start = 1'b1;
        end
      end
      BS_START: begin
        if (tmr_zero) begin
          st_d     = BS_LOW;
          tmr_load = 1'b1;
        end
      end
      BS_LOW: begin
        if (tmr_zero) begin
          st_d     = BS_HIGH;
          tmr_load = 1'b1;
          tmr_val  = hi_len;
        end
      end
      BS_HIGH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (bi_q != ACK_IDX) begin
            sh_d = {sh_q[6:0], 1'b0};
            bi_d = bi_q + 4'd1;
            st_d = BS_LOW;
          end else if (sda_in) begin
            evt.nack = 1'b1;
            st_d     = BS_PLOW;
          end else begin
            evt.ack = 1'b1;
            if (hold_vld) begin
              take = 1'b1;
              sh_d = hold_data;
              bi_d = '0;
              st_d = BS_LOW;
            end else begin
              st_d = BS_PLOW;
            end
          end
        end
      end
      BS_PLOW: begin
        if (tmr_zero) begin
          st_d     = BS_PHIGH;
          tmr_load = 1'b1;
          tmr_val  = hi_len;
        end
      end
      BS_PHIGH: begin
        if (tmr_zero) begin
          st_d     = BS_FREE;
          tmr_load = 1'b1;
          tmr_val  = hi_len;
        end
      end
      BS_FREE: begin
        if (tmr_zero) begin
          st_d     = BS_IDLE;
          evt.done = 1'b1;
        end
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BS_IDLE;
      sh_q <= '0;
      bi_q <= '0;
    end else begin
      st_q <= st_d;
      sh_q <= sh_d;
      bi_q <= bi_d;
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st_q)
      BS_START: sda_oe = 1'b1;
      BS_LOW: begin
        scl_oe = 1'b1;
        sda_oe = (bi_q != ACK_IDX) && !sh_q[7];
      end
      BS_HIGH:  sda_oe = (bi_q != ACK_IDX) && !sh_q[7];
      BS_PLOW: begin
        scl_oe = 1'b1;
        sda_oe = 1'b1;
      end
      BS_PHIGH: sda_oe = 1'b1;
      default: ;
    endcase
  end

  assign stop_busy = (st_q == BS_PLOW) || (st_q == BS_PHIGH) || (st_q == BS_FREE);
  assign st        = st_q;

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master import i2cm_pkg::*; #(
  parameter  int DIV_W = 8,
  parameter  int EXP_W = 3,
  localparam int WD_W  = 2 * DIV_W + EXP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [WD_W-1:0] wr_data,
  input  logic            sda_in,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            txrdy,
  output logic            nack,
  output logic            txcomp,
  output logic            irq
);

  localparam int CNT_W = DIV_W + 2 ** EXP_W;

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [6:0]        tgt_addr;
  logic              dir, en, hold_vld, hold_wr, take, stop_busy;
  logic [DIV_W-1:0]  ldiv, hdiv;
  logic [EXP_W-1:0]  cexp;
  logic [7:0]        hold_data;
  logic [NFLAGS-1:0] flags;
  evt_t              evt;
  bus_st_e           eng_st;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  i2cm_regs #(.DIV_W(DIV_W), .EXP_W(EXP_W), .WD_W(WD_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stop_busy(stop_busy), .evt(evt), .take(take),
    .tgt_addr(tgt_addr), .dir(dir), .ldiv(ldiv), .hdiv(hdiv), .cexp(cexp),
    .en(en), .hold_data(hold_data), .hold_vld(hold_vld), .hold_wr(hold_wr),
    .flags(flags), .irq(irq)
  );

  i2cm_engine #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_s_n), .en(en), .hold_vld(hold_vld),
    .hold_data(hold_data), .tgt_addr(tgt_addr), .dir(dir), .ldiv(ldiv),
    .hdiv(hdiv), .cexp(cexp), .sda_in(sda_in), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .take(take), .evt(evt),
    .stop_busy(stop_busy), .st(eng_st), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2cm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  assign txrdy  = flags[FLAG_TXRDY];
  assign nack   = flags[FLAG_NACK];
  assign txcomp = flags[FLAG_TXCOMP];

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk import i2cm_pkg::*; (
  input logic    clk,
  input logic    rst_n,
  input bus_st_e st,
  input logic    scl_oe,
  input logic    sda_oe,
  input logic    txrdy,
  input logic    txcomp,
  input logic    nack,
  input logic    hold_wr
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_IDLE) |-> (!scl_oe && !sda_oe));

  // R8
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ((st == BS_START) || (st == BS_FREE)));

  // R3
  wr_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !txrdy);

  // R5
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> (st == BS_PLOW));

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_START) |-> (!txcomp && !nack));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txcomp) |-> ((st == BS_IDLE) && ($past(st) == BS_FREE)));

endmodule

bind i2c_tx_master i2cm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(eng_st), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .txrdy(txrdy), .txcomp(txcomp), .nack(nack), .hold_wr(hold_wr)
);

// File: tb/sim_i2c_tx_master.sv
module sim_i2c_tx_master;

  localparam int CLK_P = 10;
  localparam int WD_W  = 19;
  localparam int NVEC  = 5;

  typedef struct packed {
    logic [6:0]  addr;
    logic        dir;
    logic [7:0]  ldiv;
    logic [7:0]  hdiv;
    logic [2:0]  cexp;
    logic [1:0]  nb;
    logic [3:0]  nk;
    logic [23:0] data;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{7'h50, 1'b0, 8'd2, 8'd1, 3'd0, 2'd1, 4'd15, 24'hA50000},
    '{7'h2C, 1'b0, 8'd1, 8'd3, 3'd1, 2'd3, 4'd15, 24'h3C81FF},
    '{7'h11, 1'b0, 8'd0, 8'd0, 3'd2, 2'd3, 4'd0,  24'h123456},
    '{7'h7F, 1'b1, 8'd3, 8'd2, 3'd0, 2'd3, 4'd2,  24'h00C35A},
    '{7'h3A, 1'b0, 8'd0, 8'd2, 3'd3, 2'd2, 4'd15, 24'h699600}
  };

  logic            clk, rst_n, wr_en;
  logic [2:0]      wr_addr;
  logic [WD_W-1:0] wr_data;
  logic            sda_in, scl_oe, sda_oe, txrdy, nack, txcomp, irq;
  logic            pull, mon_clr;
  logic [3:0]      nack_at_mon;

  int total, bad, cyc;

  // receiver model state
  logic       psl, pdl, sl, dl;
  logic [7:0] shf;
  logic [7:0] rx [0:7];
  int         bitcnt, byte_ix, starts, stops, run, low_meas, high_meas;

  i2c_tx_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .txrdy(txrdy), .nack(nack), .txcomp(txcomp), .irq(irq)
  );

  assign sda_in = !(sda_oe || pull);

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  always @(negedge clk) begin
    if (mon_clr) begin
      pull = 1'b0; psl = 1'b1; pdl = 1'b1; bitcnt = 0; byte_ix = 0;
      starts = 0; stops = 0; run = 0; low_meas = 0; high_meas = 0; shf = '0;
    end else begin
      sl = !scl_oe;
      dl = !(sda_oe || pull);
      if (sl && psl && (dl != pdl)) begin
        if (!dl) begin starts = starts + 1; bitcnt = 0; byte_ix = 0; end
        else stops = stops + 1;
      end
      if (sl && !psl) begin
        if (byte_ix == 0 && bitcnt == 0) low_meas = run;
        if (bitcnt < 8) shf = {shf[6:0], dl};
        bitcnt = bitcnt + 1;
      end
      if (!sl && psl && starts > 0) begin
        if (byte_ix == 0 && bitcnt == 1) high_meas = run;
        if (bitcnt == 8) begin
          pull = (byte_ix != int'(nack_at_mon));
        end else if (bitcnt == 9) begin
          pull = 1'b0;
          if (byte_ix < 8) rx[byte_ix] = shf;
          byte_ix = byte_ix + 1;
          bitcnt = 0;
        end
      end
      if (sl != psl) run = 1; else run = run + 1;
      psl = sl;
      pdl = dl;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [WD_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int   nexp, lo, hi;
    logic [7:0] b;
    v = VECS[i];
    nack_at_mon = v.nk;
    clear_mon();
    wreg(3'd0, WD_W'({v.dir, v.addr}));
    wreg(3'd1, {v.cexp, v.hdiv, v.ldiv});
    wreg(3'd3, WD_W'(v.data[23:16]));
    chk(txrdy == 1'b0, "R3 txrdy after write", int'(txrdy), 0);
    @(negedge clk);
    chk(txcomp == 1'b0 && nack == 1'b0, "R11 flags at start",
        int'({txcomp, nack}), 0);
    for (int j = 1; j < int'(v.nb); j++) begin
      for (int t = 0; t < 20000 && !txrdy && !txcomp; t++) @(negedge clk);
      if (txcomp) break;
      b = v.data[23 - 8*j -: 8];
      wreg(3'd3, WD_W'(b));
    end
    for (int t = 0; t < 20000 && !txcomp; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    nexp = (int'(v.nk) <= int'(v.nb)) ? int'(v.nk) + 1 : int'(v.nb) + 1;
    lo = (int'(v.ldiv) << v.cexp) + 4;
    hi = (int'(v.hdiv) << v.cexp) + 4;
    chk(txcomp == 1'b1, "R6 txcomp at end", int'(txcomp), 1);
    chk(starts == 1, "R2 one start", starts, 1);
    chk(stops == 1, "R6 one stop", stops, 1);
    chk(byte_ix == nexp, "R5 bytes on bus", byte_ix, nexp);
    chk(rx[0] == {v.addr, v.dir}, "R2 address byte", int'(rx[0]), int'({v.addr, v.dir}));
    for (int j = 1; j < nexp; j++) begin
      b = v.data[23 - 8*(j-1) -: 8];
      chk(rx[j] == b, "R3 data byte", int'(rx[j]), int'(b));
    end
    chk(nack == (v.nk != 4'd15), "R4 R5 nack flag", int'(nack), int'(v.nk != 4'd15));
    chk(irq == (v.nk != 4'd15), "R10 irq follows masked nack", int'(irq), int'(v.nk != 4'd15));
    chk(txrdy == 1'b1, "R3 txrdy at end", int'(txrdy), 1);
    chk(low_meas == lo, "R7 SCL low time", low_meas, lo);
    chk(high_meas == hi, "R7 SCL high time", high_meas, hi);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; cyc = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mon_clr = 1'b1; nack_at_mon = 4'd15;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_clr = 1'b0;

    // R1 reset state
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 bus released", int'({scl_oe, sda_oe}), 0);
    chk(txrdy == 1'b1, "R1 txrdy", int'(txrdy), 1);
    chk(txcomp == 1'b1, "R1 txcomp", int'(txcomp), 1);
    chk(nack == 1'b0, "R1 nack", int'(nack), 0);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);

    // R10 mask set and clear
    wreg(3'd4, WD_W'(3'b001));
    chk(irq == 1'b1, "R10 irq on txcomp", int'(irq), 1);
    wreg(3'd5, WD_W'(3'b001));
    chk(irq == 1'b0, "R10 irq masked off", int'(irq), 0);

    // R9 data write while off is dropped
    clear_mon();
    wreg(3'd1, {3'd0, 8'd0, 8'd0});
    wreg(3'd2, WD_W'(2'b11));
    wreg(3'd3, WD_W'(8'h77));
    repeat (50) @(negedge clk);
    chk(starts == 0 && scl_oe == 1'b0, "R9 no start while off", starts, 0);
    chk(txrdy == 1'b1, "R9 txrdy untouched", int'(txrdy), 1);
    wreg(3'd2, WD_W'(2'b01));
    repeat (50) @(negedge clk);
    chk(starts == 0, "R9 dropped byte stays dropped", starts, 0);

    wreg(3'd4, WD_W'(3'b100));
    for (int i = 0; i < NVEC; i++) run_vec(i);

    wreg(3'd5, WD_W'(3'b100));
    chk(irq == 1'b0, "R10 irq cleared", int'(irq), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule